// File: doc/BRIEF.md
# Bus Error Exception Sequencer

This block sits beside a bus interface unit and turns bus error acknowledges into processor exception requests. Each data tenure on the bus is opened by a start pulse, which also captures whether the tenure belongs to a direct-store sequence and whether it is the final tenure of that sequence. A tenure closes when the bus signals its end, or at once when the error acknowledge arrives, because an error acknowledge terminates the transfer. A transfer acknowledge that arrives in the same cycle as the error acknowledge is discarded.

For an ordinary memory tenure, the block issues the exception one cycle after the error acknowledge. The exception is a machine-check request when the machine-check enable input is high, and a checkstop request when it is low. For a direct-store sequence, the exception is held back. The sequence runs on until its final tenure has been terminated by an error acknowledge, and the exception is issued in the next cycle. No load or store reply is awaited. A direct-store tenure that closes without an error acknowledge breaks the protocol and is recorded in a separate status bit.

Both causes are kept in a sticky status vector until software clears it.

Top module: `berr_exc_seq`

## Requirements
- R1: On a memory tenure (`dstore` captured as 0), `berr_ack` high while the tenure is open gives a single-cycle pulse on exactly one of `mc_req` or `cs_req` in the next cycle. `mc_req` and `cs_req` are never high together.
- R2: The choice between machine check and checkstop uses `mchk_en` from the cycle in which the issuing condition occurs. For a deferred direct-store error this is the cycle of the final tenure's error acknowledge, not the cycle of any earlier one. `mchk_en`=1 selects `mc_req` and `mchk_en`=0 selects `cs_req`.
- R3: `xfer_ack` in an open tenure gives a `data_done` pulse one cycle later, unless `berr_ack` is high in the same cycle. An error acknowledge closes the tenure, so later `xfer_ack` pulses give no `data_done`.
- R4: On a direct-store tenure that is not the last one (`last_ten` captured as 0), `berr_ack` raises no exception request. The next tenure may be started normally.
- R5: On the last direct-store tenure, `berr_ack` raises the exception request in the next cycle, with no reply awaited.
- R6: A direct-store tenure that closes through `ten_end` without `berr_ack` sets `err_sts[1]` (protocol error) in the next cycle.
- R7: If the last direct-store tenure closes without `berr_ack` after an earlier tenure of the sequence took an error acknowledge, the held exception is still issued in the next cycle.
- R8: `err_sts[0]` (bus error) is set in the same cycle as an exception pulse. Both bits stay set until `sts_clr`. When a set and `sts_clr` fall in the same cycle, the set wins.
- R9: After reset, all outputs are 0 and no tenure is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ten_start | input | 1 | Pulse opening a data tenure |
| ten_end | input | 1 | Pulse closing a tenure normally |
| dstore | input | 1 | Tenure belongs to a direct-store sequence (captured at start) |
| last_ten | input | 1 | Final tenure of a direct-store sequence (captured at start) |
| berr_ack | input | 1 | Bus error acknowledge |
| xfer_ack | input | 1 | Transfer acknowledge |
| mchk_en | input | 1 | Machine-check enable |
| sts_clr | input | 1 | Clears the sticky status |
| mc_req | output | 1 | Machine-check request pulse |
| cs_req | output | 1 | Checkstop request pulse |
| data_done | output | 1 | Successful data beat pulse |
| err_sts | output | 2 | Sticky status: bit 0 bus error, bit 1 protocol error |

## Verification
A stale open-tenure flag shows up one cycle later as a `data_done` pulse after a terminating error, or as an error acknowledge that raises nothing. A lost or stuck deferral flag shows up when the final direct-store tenure closes: the exception is missing, or it fires on a middle tenure in the cycle after that tenure's error. A wrongly captured tenure attribute flips the choice between immediate and deferred issue, which is visible on the request pins one cycle after the acknowledge. The status bits are compared on every cycle, so a lost sticky bit is caught at the next compare.

// File: rtl/berr_exc_pkg.sv
package berr_exc_pkg;
  localparam int STS_W     = 2;
  localparam int STS_BUS   = 0;
  localparam int STS_PROTO = 1;

  typedef enum logic [1:0] {EXC_NONE, EXC_MCHK, EXC_CSTOP} exc_kind_e;

  typedef struct packed {
    logic dstore;
    logic last;
  } ten_attr_t;

  function automatic exc_kind_e pick_exc(input logic fire, input logic mchk_en);
    if (!fire)   return EXC_NONE;
    if (mchk_en) return EXC_MCHK;
    return EXC_CSTOP;
  endfunction

  function automatic logic [STS_W-1:0] sts_next(input logic [STS_W-1:0] cur,
                                                input logic clr,
                                                input logic [STS_W-1:0] set);
    return (clr ? '0 : cur) | set;
  endfunction
endpackage

// File: rtl/berr_ten_track.sv
module berr_ten_track
  import berr_exc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ten_start,
  input  logic      ten_end,
  input  logic      dstore,
  input  logic      last_ten,
  input  logic      berr_ack,
  input  logic      xfer_ack,
  output logic      open_q,
  output ten_attr_t attr_q,
  output logic      err_hit,
  output logic      clean_end,
  output logic      data_done
);
  // Error acknowledge wins over a normal end in the same cycle.
  assign err_hit   = open_q & berr_ack;
  assign clean_end = open_q & ten_end & ~berr_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      attr_q    <= '0;
      data_done <= 1'b0;
    end else begin
      if (ten_start) begin
        open_q <= 1'b1;
        attr_q <= '{dstore: dstore, last: last_ten};
      end else if (err_hit || clean_end) begin
        open_q <= 1'b0;
      end
      data_done <= open_q & xfer_ack & ~berr_ack;
    end
  end
endmodule

// File: rtl/berr_defer.sv
module berr_defer
  import berr_exc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      err_hit,
  input  logic      clean_end,
  input  ten_attr_t attr_q,
  input  logic      mchk_en,
  output logic      issue_now,
  output logic      ds_mid_err,
  output logic      ds_bad_end,
  output logic      mc_req,
  output logic      cs_req
);
  logic      pend_q;
  logic      mem_err;
  logic      ds_last_err;
  logic      ds_last_bad;
  exc_kind_e kind;

  assign mem_err     = err_hit & ~attr_q.dstore;
  assign ds_last_err = err_hit & attr_q.dstore & attr_q.last;
  assign ds_mid_err  = err_hit & attr_q.dstore & ~attr_q.last;
  assign ds_bad_end  = clean_end & attr_q.dstore;
  assign ds_last_bad = ds_bad_end & attr_q.last & pend_q;
  assign issue_now   = mem_err | ds_last_err | ds_last_bad;
  assign kind        = pick_exc(issue_now, mchk_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mc_req <= 1'b0;
      cs_req <= 1'b0;
    end else begin
      if (issue_now)       pend_q <= 1'b0;
      else if (ds_mid_err) pend_q <= 1'b1;
      mc_req <= (kind == EXC_MCHK);
      cs_req <= (kind == EXC_CSTOP);
    end
  end
endmodule

// File: rtl/berr_status.sv
module berr_status
  import berr_exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_bus,
  input  logic             set_proto,
  input  logic             sts_clr,
  output logic [STS_W-1:0] err_sts
);
  logic [STS_W-1:0] set_vec;

  always_comb begin
    set_vec            = '0;
    set_vec[STS_BUS]   = set_bus;
    set_vec[STS_PROTO] = set_proto;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_sts <= '0;
    else        err_sts <= sts_next(err_sts, sts_clr, set_vec);
  end
endmodule

// File: rtl/berr_exc_seq.sv
module berr_exc_seq
  import berr_exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ten_start,
  input  logic             ten_end,
  input  logic             dstore,
  input  logic             last_ten,
  input  logic             berr_ack,
  input  logic             xfer_ack,
  input  logic             mchk_en,
  input  logic             sts_clr,
  output logic             mc_req,
  output logic             cs_req,
  output logic             data_done,
  output logic [STS_W-1:0] err_sts
);
  logic      open_q;
  ten_attr_t attr_q;
  logic      err_hit;
  logic      clean_end;
  logic      issue_now;
  logic      ds_mid_err;
  logic      ds_bad_end;

  berr_ten_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .ten_start (ten_start),
    .ten_end   (ten_end),
    .dstore    (dstore),
    .last_ten  (last_ten),
    .berr_ack  (berr_ack),
    .xfer_ack  (xfer_ack),
    .open_q    (open_q),
    .attr_q    (attr_q),
    .err_hit   (err_hit),
    .clean_end (clean_end),
    .data_done (data_done)
  );

  berr_defer u_defer (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_hit    (err_hit),
    .clean_end  (clean_end),
    .attr_q     (attr_q),
    .mchk_en    (mchk_en),
    .issue_now  (issue_now),
    .ds_mid_err (ds_mid_err),
    .ds_bad_end (ds_bad_end),
    .mc_req     (mc_req),
    .cs_req     (cs_req)
  );

  berr_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_bus   (issue_now),
    .set_proto (ds_bad_end),
    .sts_clr   (sts_clr),
    .err_sts   (err_sts)
  );
endmodule

// File: rtl/berr_exc_seq_chk.sv
module berr_exc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       err_hit,
  input logic       issue_now,
  input logic       ds_mid_err,
  input logic       ds_bad_end,
  input logic       mchk_en,
  input logic       sts_clr,
  input logic       mc_req,
  input logic       cs_req,
  input logic       data_done,
  input logic [1:0] err_sts
);
  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mc_req, cs_req}));

  p_mce_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_now && mchk_en) |=> (mc_req && !cs_req));

  p_ta_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> !data_done);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ds_mid_err |=> !(mc_req || cs_req));

  p_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_now |=> (mc_req || cs_req));

  p_proto_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ds_bad_end |=> err_sts[1]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sts[0] && !sts_clr) |=> err_sts[0]);
endmodule

bind berr_exc_seq berr_exc_seq_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .err_hit    (err_hit),
  .issue_now  (issue_now),
  .ds_mid_err (ds_mid_err),
  .ds_bad_end (ds_bad_end),
  .mchk_en    (mchk_en),
  .sts_clr    (sts_clr),
  .mc_req     (mc_req),
  .cs_req     (cs_req),
  .data_done  (data_done),
  .err_sts    (err_sts)
);

// File: tb/test_berr_exc_seq.sv
`timescale 1ns/100ps
module test_berr_exc_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ten_start = 0, ten_end = 0, dstore = 0, last_ten = 0;
  logic       berr_ack = 0, xfer_ack = 0, mchk_en = 0, sts_clr = 0;
  logic       mc_req, cs_req, data_done;
  logic [1:0] err_sts;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic       mc;
    logic       cs;
    logic       dd;
    logic [1:0] sts;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  berr_exc_seq i_berr_exc_seq (
    .clk(clk), .rst_n(rst_n), .ten_start(ten_start), .ten_end(ten_end),
    .dstore(dstore), .last_ten(last_ten), .berr_ack(berr_ack),
    .xfer_ack(xfer_ack), .mchk_en(mchk_en), .sts_clr(sts_clr),
    .mc_req(mc_req), .cs_req(cs_req), .data_done(data_done), .err_sts(err_sts)
  );

  // Driver: apply one cycle of stimulus and queue the outputs expected after the edge.
  task automatic step(input logic st, en, ds, ls, be, xa, me, cl,
                      input logic emc, ecs, edd, input logic [1:0] ests,
                      input string tag);
    exp_t e;
    @(negedge clk);
    ten_start = st; ten_end = en; dstore = ds; last_ten = ls;
    berr_ack = be;  xfer_ack = xa; mchk_en = me; sts_clr = cl;
    e.mc = emc; e.cs = ecs; e.dd = edd; e.sts = ests; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare just after each edge.
  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (mc_req !== e.mc || cs_req !== e.cs || data_done !== e.dd || err_sts !== e.sts) begin
        fails++;
        $display("FAIL %s: got mc=%b cs=%b dd=%b sts=%b, expected mc=%b cs=%b dd=%b sts=%b",
                 e.tag, mc_req, cs_req, data_done, err_sts, e.mc, e.cs, e.dd, e.sts);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //     st en ds ls be xa me cl   mc cs dd sts
    step(0,0,0,0,0,0,0,0, 0,0,0,2'b00, "R9 reset state");
    step(0,0,0,0,1,1,1,0, 0,0,0,2'b00, "R9 no tenure open");
    // Memory tenure, machine check
    step(1,0,0,0,0,0,1,0, 0,0,0,2'b00, "R1 open mem");
    step(0,0,0,0,1,0,1,0, 1,0,0,2'b01, "R1 mem mchk");
    step(0,0,0,0,0,0,1,0, 0,0,0,2'b01, "R1 single pulse / R8 sticky");
    step(0,0,0,0,0,0,0,0, 0,0,0,2'b01, "R8 sticky hold");
    step(0,0,0,0,0,0,0,1, 0,0,0,2'b00, "R8 clear");
    // Memory tenure, checkstop
    step(1,0,0,0,0,0,0,0, 0,0,0,2'b00, "R1 open mem2");
    step(0,0,0,0,1,0,0,0, 0,1,0,2'b01, "R2 mem cstop");
    step(0,0,0,0,0,0,0,1, 0,0,0,2'b00, "R1 cstop single pulse");
    // Transfer acks
    step(1,0,0,0,0,0,0,0, 0,0,0,2'b00, "R3 open");
    step(0,0,0,0,0,1,0,0, 0,0,1,2'b00, "R3 beat done");
    step(0,0,0,0,1,1,1,0, 1,0,0,2'b01, "R3 ta dropped with error");
    step(0,0,0,0,0,1,1,0, 0,0,0,2'b01, "R3 ta after close");
    step(0,0,0,0,0,0,0,1, 0,0,0,2'b00, "R3 clear");
    step(1,0,0,0,0,0,0,0, 0,0,0,2'b00, "R3 open normal");
    step(0,1,0,0,0,0,0,0, 0,0,0,2'b00, "R3 normal end mem no proto");
    step(0,0,0,0,0,1,0,0, 0,0,0,2'b00, "R3 ta after normal end");
    // Direct-store sequence, mchk_en changes between first and last error
    step(1,0,1,0,0,0,0,0, 0,0,0,2'b00, "R4 open ds1");
    step(0,0,0,0,1,0,0,0, 0,0,0,2'b00, "R4 ds1 error held");
    step(1,0,1,0,0,0,0,0, 0,0,0,2'b00, "R4 open ds2");
    step(0,0,0,0,1,0,0,0, 0,0,0,2'b00, "R4 ds2 error held");
    step(1,0,1,1,0,0,0,0, 0,0,0,2'b00, "R4 open last");
    step(0,0,0,0,1,0,1,0, 1,0,0,2'b01, "R5 R2 last error issues mchk");
    step(0,0,0,0,0,0,0,0, 0,0,0,2'b01, "R5 single pulse");
    step(0,0,0,0,0,0,0,1, 0,0,0,2'b00, "R5 clear");
    // Direct-store single last tenure with checkstop
    step(1,0,1,1,0,0,1,0, 0,0,0,2'b00, "R5 open solo last");
    step(0,0,0,0,1,0,0,0, 0,1,0,2'b01, "R2 R5 solo last cstop");
    step(0,0,0,0,0,0,0,1, 0,0,0,2'b00, "R5 clear2");
    // Protocol error
    step(1,0,1,0,0,0,0,0, 0,0,0,2'b00, "R6 open ds");
    step(0,1,0,0,0,0,0,0, 0,0,0,2'b10, "R6 clean ds end");
    step(0,0,0,0,0,0,0,0, 0,0,0,2'b10, "R6 proto sticky");
    step(0,0,0,0,0,0,0,1, 0,0,0,2'b00, "R6 clear");
    // Held error released by clean last end
    step(1,0,1,0,0,0,0,0, 0,0,0,2'b00, "R7 open ds");
    step(0,0,0,0,1,0,1,0, 0,0,0,2'b00, "R7 held");
    step(1,0,1,1,0,0,1,0, 0,0,0,2'b00, "R7 open last");
    step(0,1,0,0,0,0,0,0, 0,1,0,2'b11, "R7 clean last releases held");
    step(0,0,0,0,0,0,0,1, 0,0,0,2'b00, "R7 clear");
    // Set wins over clear
    step(1,0,0,0,0,0,0,0, 0,0,0,2'b00, "R8 open");
    step(0,0,0,0,1,0,1,1, 1,0,0,2'b01, "R8 set beats clear");
    step(0,0,0,0,0,0,0,1, 0,0,0,2'b00, "R8 final clear");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule